// File: doc/BRIEF.md
# Event-Flag Serial Port

This block is a memory-mapped asynchronous serial port with a single interrupt line. Software talks to it over a simple word bus: a write strobe with address and data taken on the rising clock edge, and a read path that returns the addressed register in the same cycle with no side effects. Writing the data register starts a byte on the serial output. The byte most recently received from the serial input is read back from that same register.

Completion of a transmitted byte and arrival of a received byte each raise a sticky event flag in the status register. Software clears a flag by writing a one to its bit. Each flag has its own interrupt enable. The interrupt line is the OR of the enabled flags.

While the receive flag is set, the receiver keeps the held byte. A frame that completes during that time is discarded and recorded in an overrun flag. One divisor register sets the bit time for both directions. A received frame whose stop bit samples low is dropped without raising any flag.

Top module: `uart_evt_top`

## Requirements
- R1: After reset, every register reads zero except the status register, which reads 0x1 (bit 0, transmitter idle). After reset, irq is low and ser_tx is high.
- R2: The register index is reg_addr shifted right by two. The indices are 0 data, 1 divisor, 2 status, 3 control and 4 debug. The divisor keeps its low DIV_W bits. The control register keeps bits 2:0: bit 0 is the receive interrupt enable, bit 1 the transmit interrupt enable, and bit 2 a stored flag with no function. The debug register keeps bit 0. All other bits read zero. Indices 5 and above read zero and ignore writes. A write to index 0 does not change the value read there.
- R3: A write to index 0 while status bit 0 is high sends reg_wdata[7:0] on ser_tx as one frame: a low start bit, eight data bits least significant first, and a high stop bit. Each bit lasts divisor+1 clocks. Status bit 0 is low for exactly 10*(divisor+1) clocks, starting at the write edge.
- R4: A write to index 0 while status bit 0 is low is ignored. No second frame follows the current one.
- R5: Status bit 2 (transmit event) is set on the same edge at which status bit 0 returns high after a frame.
- R6: The receiver finds a start bit by the falling edge of ser_rx after a two-stage synchronizer. It samples each bit ceil(divisor/2) clocks into the bit. When the receive event flag is clear, a frame with a high stop bit loads its byte into index 0 (bits 7:0) and sets status bit 1 (receive event).
- R7: A frame that completes while status bit 1 is set leaves index 0 unchanged and sets status bit 3 (overrun).
- R8: A write to index 2 clears each of status bits 1, 2 and 3 whose write bit is one. Zero bits and bit 0 are unaffected.
- R9: irq equals (control bit 0 AND status bit 1) OR (control bit 1 AND status bit 2). It follows a change of either register on the same edge.
- R10: A received frame whose stop bit samples low changes no register and raises no flag. The receiver then accepts the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wen | input | 1 | Write strobe, taken on the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, same cycle |
| irq | output | 1 | Interrupt request, active high |
| ser_tx | output | 1 | Serial output, idle high |
| ser_rx | input | 1 | Serial input, idle high |

## Verification
The bench sweeps several divisors, including zero, with bytes whose edge bits differ. A receiver that samples one clock off, or a transmitter that miscounts the bit time, shows up as a shifted byte or a wrong frame length. It writes the data register a second time mid-frame, where a design that accepted the write would corrupt the frame or start a second one. It sends a second frame before the first is acknowledged, so a design that overwrote the held byte or skipped the overrun flag is caught. It clears status bits one at a time to catch clears that touch neighbouring bits. It walks every enable against every flag combination, where a swapped or missing gate on the interrupt shows directly.

// File: rtl/uart_evt_pkg.sv
// Shared constants for the event-flag serial port: register indices,
// status and control bit positions, and frame geometry.
package uart_evt_pkg;
    localparam int REG_W      = 32;
    localparam int BYTE_W     = 8;
    localparam int FRAME_BITS = BYTE_W + 2;

    // Register indices (byte address / 4)
    localparam int IDX_DATA = 0;
    localparam int IDX_DIV  = 1;
    localparam int IDX_STAT = 2;
    localparam int IDX_CTRL = 3;
    localparam int IDX_DBG  = 4;

    // Status bit positions
    localparam int ST_IDLE = 0;
    localparam int ST_RXEV = 1;
    localparam int ST_TXEV = 2;
    localparam int ST_OVR  = 3;

    // Control bit positions and width
    localparam int CT_RXIE = 0;
    localparam int CT_TXIE = 1;
    localparam int CTRL_W  = 3;
endpackage

// File: rtl/uart_evt_tx.sv
// Transmit shifter. It sends one 8N1 frame per start pulse and holds each
// bit for div+1 clocks. Assumes: start is raised only while busy is low
// (the register block gates it). done pulses on the edge that ends the
// stop bit, which is the same edge at which busy falls.
module uart_evt_tx
    import uart_evt_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div,
    input  logic              start,
    input  logic [BYTE_W-1:0] data,
    output logic              busy,
    output logic              done,
    output logic              line
);
    localparam int CNT_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    logic                  busy_q;
    logic [DIV_W-1:0]      cnt_q;
    logic [CNT_W-1:0]      bit_q;
    logic [FRAME_BITS-1:0] frame_q;
    logic                  tick;

    assign tick = busy_q && (cnt_q == '0);
    assign done = tick && (bit_q == LAST_BIT);
    assign busy = busy_q;
    assign line = busy_q ? frame_q[0] : 1'b1;

    // Load a frame on start, then step one bit every div+1 clocks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            bit_q   <= '0;
            frame_q <= '1;
        end else if (start) begin
            busy_q  <= 1'b1;
            cnt_q   <= div;
            bit_q   <= '0;
            frame_q <= {1'b1, data, 1'b0};
        end else if (busy_q) begin
            if (tick) begin
                cnt_q   <= div;
                frame_q <= {1'b1, frame_q[FRAME_BITS-1:1]};
                if (done) begin
                    busy_q <= 1'b0;
                end else begin
                    bit_q <= bit_q + 1'b1;
                end
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q);  // R4
    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !done) |=> busy_q);  // R3
endmodule

// File: rtl/uart_evt_rx.sv
// Receive sampler. It synchronizes the serial input, detects the falling
// edge of a start bit, and samples each bit ceil(div/2) clocks into it.
// It presents a byte with a one-cycle valid pulse when the stop bit is
// high. A start bit that samples high, or a low stop bit, drops the
// frame. Assumes: SYNC_STAGES >= 2.
module uart_evt_rx
    import uart_evt_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div,
    input  logic              line_in,
    output logic              valid,
    output logic [BYTE_W-1:0] byte_o
);
    localparam int CNT_W = $clog2(FRAME_BITS);
    localparam int TOP   = SYNC_STAGES - 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   active_q;
    logic [DIV_W-1:0]       cnt_q;
    logic [CNT_W-1:0]       bit_q;
    logic [BYTE_W-1:0]      shift_q;
    logic                   valid_q;
    logic                   sample;
    logic                   fall;
    logic [DIV_W-1:0]       half;

    assign sample = sync_q[TOP];
    assign fall   = sync_q[TOP] && !sync_q[TOP-1];
    assign half   = (div >> 1) + {{(DIV_W-1){1'b0}}, div[0]};
    assign valid  = valid_q;
    assign byte_o = shift_q;

    // Shift the raw input through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[TOP-1:0], line_in};
        end
    end

    // Frame sampler: arm on a start edge, sample mid-bit, flag the stop bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            bit_q    <= '0;
            shift_q  <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (!active_q) begin
                if (fall) begin
                    active_q <= 1'b1;
                    cnt_q    <= half;
                    bit_q    <= '0;
                end
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end else begin
                cnt_q <= div;
                bit_q <= bit_q + 1'b1;
                if (bit_q == '0) begin
                    if (sample) begin
                        active_q <= 1'b0;
                    end
                end else if (bit_q == LAST_BIT) begin
                    active_q <= 1'b0;
                    valid_q  <= sample;
                end else begin
                    shift_q <= {sample, shift_q[BYTE_W-1:1]};
                end
            end
        end
    end

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);  // R6
    AST_VALID_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> !active_q);  // R10
endmodule

// File: rtl/uart_evt_regs.sv
// Register file and event logic. It decodes word-indexed accesses and
// holds the divisor, control, debug and received-byte registers and the
// sticky event flags, and it forms the interrupt. Assumes: tx_done
// coincides with the falling edge of tx_busy. rx_valid is a one-cycle
// pulse. DIV_W <= 32.
module uart_evt_regs
    import uart_evt_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              tx_busy,
    input  logic              tx_done,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [DIV_W-1:0]  div,
    output logic              tx_start,
    output logic [BYTE_W-1:0] tx_data,
    output logic              irq
);
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] SEL_DATA = IDX_W'(IDX_DATA);
    localparam logic [IDX_W-1:0] SEL_DIV  = IDX_W'(IDX_DIV);
    localparam logic [IDX_W-1:0] SEL_STAT = IDX_W'(IDX_STAT);
    localparam logic [IDX_W-1:0] SEL_CTRL = IDX_W'(IDX_CTRL);
    localparam logic [IDX_W-1:0] SEL_DBG  = IDX_W'(IDX_DBG);

    logic [IDX_W-1:0]  idx;
    logic [DIV_W-1:0]  div_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              brk_q;
    logic [BYTE_W-1:0] hold_q;
    logic              rxev_q, txev_q, ovr_q;
    logic              stat_wr;
    logic              clr_rx, clr_tx, clr_ovr;
    logic              rxev_kept;
    logic              accept;
    logic              unused_bits;

    assign idx         = reg_addr[ADDR_W-1:2];
    assign unused_bits = ^{reg_addr[1:0], reg_wdata};
    assign stat_wr     = reg_wen && (idx == SEL_STAT);
    assign clr_rx      = stat_wr && reg_wdata[ST_RXEV];
    assign clr_tx      = stat_wr && reg_wdata[ST_TXEV];
    assign clr_ovr     = stat_wr && reg_wdata[ST_OVR];
    assign rxev_kept   = rxev_q && !clr_rx;
    assign accept      = rx_valid && !rxev_kept;

    assign tx_start = reg_wen && (idx == SEL_DATA) && !tx_busy;
    assign tx_data  = reg_wdata[BYTE_W-1:0];
    assign div      = div_q;
    assign irq      = (ctrl_q[CT_RXIE] && rxev_q) || (ctrl_q[CT_TXIE] && txev_q);

    // Software-owned configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            ctrl_q <= '0;
            brk_q  <= 1'b0;
        end else if (reg_wen) begin
            if (idx == SEL_DIV)  div_q  <= reg_wdata[DIV_W-1:0];
            if (idx == SEL_CTRL) ctrl_q <= reg_wdata[CTRL_W-1:0];
            if (idx == SEL_DBG)  brk_q  <= reg_wdata[0];
        end
    end

    // Received byte and receive/overrun flags; a held byte is never replaced
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            rxev_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (accept) begin
                hold_q <= rx_byte;
            end
            rxev_q <= accept || rxev_kept;
            ovr_q  <= (rx_valid && rxev_kept) || (ovr_q && !clr_ovr);
        end
    end

    // Transmit event flag: set as the frame ends, setting wins over clearing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txev_q <= 1'b0;
        end else begin
            txev_q <= tx_done || (txev_q && !clr_tx);
        end
    end

    // Read mux; unused bits and unknown indices return zero
    always_comb begin
        reg_rdata = '0;
        unique case (idx)
            SEL_DATA: reg_rdata[BYTE_W-1:0] = hold_q;
            SEL_DIV:  reg_rdata[DIV_W-1:0]  = div_q;
            SEL_STAT: begin
                reg_rdata[ST_IDLE] = !tx_busy;
                reg_rdata[ST_RXEV] = rxev_q;
                reg_rdata[ST_TXEV] = txev_q;
                reg_rdata[ST_OVR]  = ovr_q;
            end
            SEL_CTRL: reg_rdata[CTRL_W-1:0] = ctrl_q;
            SEL_DBG:  reg_rdata[0]          = brk_q;
            default:  reg_rdata = '0;
        endcase
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        rxev_kept |=> $stable(hold_q));  // R7
    AST_OVR_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rxev_kept) |=> (ovr_q && rxev_q));  // R7
    AST_W1C_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rx && !rx_valid) |=> !rxev_q);  // R8
    AST_TXEV_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_busy) |-> txev_q);  // R5
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rxev_q || txev_q));  // R9
endmodule

// File: rtl/uart_evt_top.sv
// Event-flag serial port top. It connects the register block to the
// transmit shifter and the receive sampler. Assumes: a single clock
// domain for the bus. ser_rx may be asynchronous.
module uart_evt_top
    import uart_evt_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq,
    output logic              ser_tx,
    input  logic              ser_rx
);
    logic [DIV_W-1:0]  div;
    logic              tx_start, tx_busy, tx_done;
    logic [BYTE_W-1:0] tx_data;
    logic              rx_valid;
    logic [BYTE_W-1:0] rx_byte;

    uart_evt_regs #(.DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_busy(tx_busy), .tx_done(tx_done),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .div(div), .tx_start(tx_start), .tx_data(tx_data), .irq(irq)
    );

    uart_evt_tx #(.DIV_W(DIV_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .div(div),
        .start(tx_start), .data(tx_data),
        .busy(tx_busy), .done(tx_done), .line(ser_tx)
    );

    uart_evt_rx #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk(clk), .rst_n(rst_n), .div(div), .line_in(ser_rx),
        .valid(rx_valid), .byte_o(rx_byte)
    );
endmodule

// File: tb/uart_evt_top_bench.sv
module uart_evt_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;
    localparam int WATCHDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_wen = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              irq;
    logic              ser_tx;
    logic              ser_rx = 1'b1;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;

    uart_evt_top #(.DIV_W(16), .ADDR_W(ADDR_W), .SYNC_STAGES(2)) u_uart_evt_top (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .ser_tx(ser_tx), .ser_rx(ser_rx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == WATCHDOG) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual=%0d cycles expected=completion", cycles);
            summary();
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] val);
        @(negedge clk);
        reg_addr  = ADDR_W'(idx * 4);
        reg_wdata = val;
        reg_wen   = 1'b1;
        @(posedge clk);
        #1;
        reg_wen  = 1'b0;
        reg_addr = ADDR_W'(2 * 4);
    endtask

    task automatic rd(input int idx, output logic [31:0] val);
        @(negedge clk);
        reg_addr = ADDR_W'(idx * 4);
        #1;
        val = reg_rdata;
    endtask

    task automatic wait_idle();
        int guard = 0;
        reg_addr = ADDR_W'(2 * 4);
        do begin
            @(negedge clk);
            guard++;
        end while (!reg_rdata[0] && guard < 2000);
    endtask

    // Records ser_tx each clock while status bit 0 is low, then checks length and bits
    task automatic tx_frame(input logic [7:0] b, input int d, input int j0, input string tag);
        logic line [0:511];
        logic [9:0] expf;
        int j;
        expf = {1'b1, b, 1'b0};
        j = j0;
        forever begin
            @(negedge clk);
            if (reg_rdata[0] || j > 500) break;
            line[j] = ser_tx;
            j++;
        end
        check({tag, " R3 frame length"}, 32'(j), 32'(10 * d));
        for (int i = 0; i < 10; i++)
            check({tag, " R3 frame bit"}, {31'b0, line[i * d + d / 2]}, {31'b0, expf[i]});
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stopb, input int d);
        logic [9:0] f;
        f = {stopb, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            ser_rx = f[i];
            repeat (d - 1) @(negedge clk);
        end
        @(negedge clk);
        ser_rx = 1'b1;
        repeat (d + 6) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        int divs[4] = '{0, 1, 3, 6};
        logic [7:0] bytes[6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
        bit ok;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values over the first sixteen indices
        for (int i = 0; i < 16; i++) begin
            rd(i, v);
            check($sformatf("R1 reset idx %0d", i), v, (i == 2) ? 32'h1 : 32'h0);
        end
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        check("R1 ser_tx after reset", {31'b0, ser_tx}, 32'h1);

        // R2: write all ones everywhere except data and status, read back masks
        for (int i = 1; i < 16; i++) if (i != 2) wr(i, 32'hFFFF_FFFF);
        for (int i = 0; i < 16; i++) begin
            logic [31:0] e;
            e = (i == 1) ? 32'hFFFF : (i == 2) ? 32'h1 : (i == 3) ? 32'h7 : (i == 4) ? 32'h1 : 32'h0;
            rd(i, v);
            check($sformatf("R2 readback idx %0d", i), v, e);
        end
        wr(3, 0); wr(4, 0);

        // R3 R5 R8: transmit sweep over divisors and bytes
        foreach (divs[a]) begin
            foreach (bytes[k]) begin
                wr(1, divs[a]);
                wr(0, {24'hABCDEF, bytes[k]});
                tx_frame(bytes[k], divs[a] + 1, 0, $sformatf("div %0d byte %0h", divs[a], bytes[k]));
                rd(2, v);
                check("R5 tx event with idle", v, 32'h5);
                rd(0, v);
                check("R2 data write leaves read value", v, 32'h0);
                wr(2, 32'h4);
                rd(2, v);
                check("R8 tx event cleared", v, 32'h1);
            end
        end

        // R4: second write during a frame is ignored
        wr(1, 3);
        wr(0, 32'h3C);
        wr(0, 32'hC3);
        tx_frame(8'h3C, 4, 1, "R4 busy write");
        ok = 1'b1;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (!ser_tx || !reg_rdata[0]) ok = 1'b0;
        end
        check("R4 no second frame", {31'b0, ok}, 32'h1);
        wr(2, 32'h4);

        // R6 R8: receive sweep over divisors and bytes
        foreach (divs[a]) begin
            wr(1, divs[a]);
            foreach (bytes[k]) begin
                send_rx(bytes[k] ^ 8'h3C, 1'b1, divs[a] + 1);
                rd(0, v);
                check($sformatf("R6 rx byte div %0d", divs[a]), v, {24'h0, bytes[k] ^ 8'h3C});
                rd(2, v);
                check("R6 rx event set", v, 32'h3);
                wr(2, 32'h2);
                rd(2, v);
                check("R8 rx event cleared", v, 32'h1);
            end
        end

        // R7 R8: overrun and per-bit clearing
        wr(1, 2);
        send_rx(8'h96, 1'b1, 3);
        send_rx(8'h69, 1'b1, 3);
        rd(0, v);  check("R7 held byte kept", v, 32'h96);
        rd(2, v);  check("R7 overrun set", v, 32'hB);
        wr(2, 32'h8); rd(2, v); check("R8 only overrun cleared", v, 32'h3);
        wr(2, 32'h0); rd(2, v); check("R8 zero write no effect", v, 32'h3);
        wr(2, 32'h1); rd(2, v); check("R8 idle bit unaffected", v, 32'h3);
        wr(2, 32'h2); rd(2, v); check("R8 rx cleared", v, 32'h1);
        send_rx(8'h0F, 1'b1, 3);
        rd(0, v);  check("R7 accepted after clear", v, 32'h0F);
        wr(2, 32'h2);

        // R10: bad stop bit dropped, next frame accepted
        send_rx(8'h77, 1'b0, 3);
        rd(2, v);  check("R10 no flag on bad stop", v, 32'h1);
        rd(0, v);  check("R10 data unchanged", v, 32'h0F);
        send_rx(8'h55, 1'b1, 3);
        rd(0, v);  check("R10 recovery frame", v, 32'h55);
        wr(2, 32'h2);

        // R9: every enable against every flag combination
        wr(1, 0);
        wr(0, 32'h11); wait_idle();
        send_rx(8'h22, 1'b1, 1);
        for (int c = 0; c < 4; c++) begin
            wr(3, c);
            check($sformatf("R9 both flags ctrl %0d", c), {31'b0, irq}, 32'(((c & 1) | (c >> 1)) & 1));
        end
        wr(2, 32'h4);
        for (int c = 0; c < 4; c++) begin
            wr(3, c);
            check($sformatf("R9 rx flag ctrl %0d", c), {31'b0, irq}, 32'(c & 1));
        end
        wr(2, 32'h2);
        for (int c = 0; c < 4; c++) begin
            wr(3, c);
            check($sformatf("R9 no flag ctrl %0d", c), {31'b0, irq}, 32'h0);
        end
        wr(3, 2);
        wr(0, 32'h44); wait_idle();
        check("R9 irq with tx event edge", {31'b0, irq}, 32'h1);
        for (int c = 0; c < 4; c++) begin
            wr(3, c);
            check($sformatf("R9 tx flag ctrl %0d", c), {31'b0, irq}, 32'((c >> 1) & 1));
        end

        summary();
    end
endmodule